// File: doc/BRIEF.md
# Debug Mode Status Register Controller

This block holds the status and control byte of an on-chip background debug unit. It keeps three flags. The first says whether debug mode may be entered. The second says whether debug mode is running. The third says whether instruction tagging is armed. From these flags it drives three outputs: one maps the debug ROM and debug registers into the address space, one enables the serial command interface, and one enables the tag function.

Software changes the flags in two ways. A byte write targets either the instruction byte or the status byte. A 16-bit word write stores its high byte in the instruction byte and its low byte in the status byte in the same cycle. Reads return the written flag values at once. The map and tag outputs follow only after fixed delays. The debug-entry strobe takes effect at once: it sets the active flag, maps the ROM and disarms tagging.

A word write that clears the active flag while the flag is set would remove the debug ROM under running debug code. The block records this runaway hazard in a sticky error output.

Top module: `dbgsr_top`

## Requirements
- R1: Synchronous active-high reset. The enable flag is loaded from `special_mode` and every other flag is cleared. After reset, `map_en`, `tag_en` and `runaway_err` are 0, `serial_en` is 1, and the instruction byte reads 0x00.
- R2: The status byte has the enable flag at bit 7, the active flag at bit 6, the tag flag at bit 5, and bits 4:0 read 0. `rd_addr`=1 selects the status byte and `rd_addr`=0 selects the instruction byte. A read shows a written value immediately after the write edge.
- R3: A `dbg_enter` pulse while the enable flag is 1 has these effects after that edge: the active flag and `map_en` are 1, the tag flag and `tag_en` are 0, and any pending active-flag change is cancelled. Entry wins over a status write in the same cycle.
- R4: A `dbg_enter` pulse while the enable flag is 0 is ignored. The flags, `map_en` and `tag_en` do not change.
- R5: A status write that changes the active flag reaches `map_en` exactly ACT_DLY clock edges after the write edge.
- R6: A status write to the tag flag, or a `tag_go` pulse (which sets the flag to 1), reaches `tag_en` exactly TAG_DLY edges later. `serial_en` is always the inverse of `tag_en`.
- R7: A new write while a delay is pending restarts that delay with the new value. The older value never reaches the output.
- R8: A word write stores bits 15:8 in the instruction byte and bits 7:0 in the status byte in the same cycle.
- R9: A word write that clears the active flag while the flag reads 1 sets `runaway_err`. The error stays set until reset. A byte write that clears the flag does not set the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | Reset-mode selection, loaded into the enable flag during reset |
| byte_wr | input | 1 | Byte write strobe |
| byte_addr | input | 1 | Byte write target: 0 instruction, 1 status |
| byte_wdata | input | 8 | Byte write data |
| word_wr | input | 1 | Word write strobe (instruction and status together) |
| word_wdata | input | 16 | Word write data, high byte to instruction |
| rd_addr | input | 1 | Read select: 0 instruction, 1 status |
| rd_data | output | 8 | Read data |
| dbg_enter | input | 1 | Debug-entry strobe |
| tag_go | input | 1 | Tag-go command strobe |
| map_en | output | 1 | Debug ROM and registers mapped |
| serial_en | output | 1 | Serial command interface enabled |
| tag_en | output | 1 | Tag function enabled |
| runaway_err | output | 1 | Sticky runaway error |

## Verification
The bench builds the block with ACT_DLY=3 and TAG_DLY=5. With delays this short it can sweep all eight combinations of the three status flags and watch every cycle of both delay windows for each write. The short windows also make it cheap to place a second write or an entry strobe inside a pending window, and to check from the ports which value wins.

// File: rtl/dbgsr_pkg.sv
package dbgsr_pkg;
  localparam int EN_BIT  = 7;
  localparam int ACT_BIT = 6;
  localparam int TAG_BIT = 5;

  typedef struct packed {
    logic en;
    logic act;
    logic tag;
  } flags_t;

  function automatic flags_t unpack_status(input logic [7:0] b);
    flags_t f;
    f.en  = b[EN_BIT];
    f.act = b[ACT_BIT];
    f.tag = b[TAG_BIT];
    return f;
  endfunction

  function automatic logic [7:0] pack_status(input flags_t f);
    logic [7:0] b;
    b = '0;
    b[EN_BIT]  = f.en;
    b[ACT_BIT] = f.act;
    b[TAG_BIT] = f.tag;
    return b;
  endfunction

  function automatic int delay_cnt_w(input int dly);
    return (dly < 1) ? 1 : $clog2(dly + 1);
  endfunction
endpackage

// File: rtl/dbgsr_delay.sv
module dbgsr_delay #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_val,
  input  logic force_set,
  input  logic force_val,
  output logic eff,
  output logic pending,
  output logic apply
);
  localparam int CW = dbgsr_pkg::delay_cnt_w(DLY);

  logic [CW-1:0] cnt;
  logic          pend_val;

  assign pending = (cnt != '0);
  assign apply   = (cnt == CW'(1)) && !load && !force_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      pend_val <= 1'b0;
      eff      <= 1'b0;
    end else if (force_set) begin
      cnt <= '0;
      eff <= force_val;
    end else if (load) begin
      cnt      <= CW'(DLY);
      pend_val <= load_val;
    end else if (pending) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) eff <= pend_val;
    end
  end
endmodule

// File: rtl/dbgsr_wdec.sv
module dbgsr_wdec (
  input  logic        byte_wr,
  input  logic        byte_addr,
  input  logic [7:0]  byte_wdata,
  input  logic        word_wr,
  input  logic [15:0] word_wdata,
  output logic        instr_we,
  output logic [7:0]  instr_d,
  output logic        stat_we,
  output logic [7:0]  stat_d,
  output logic        via_word
);
  always_comb begin
    via_word = word_wr;
    if (word_wr) begin
      instr_we = 1'b1;
      instr_d  = word_wdata[15:8];
      stat_we  = 1'b1;
      stat_d   = word_wdata[7:0];
    end else begin
      instr_we = byte_wr && !byte_addr;
      instr_d  = byte_wdata;
      stat_we  = byte_wr && byte_addr;
      stat_d   = byte_wdata;
    end
  end
endmodule

// File: rtl/dbgsr_top.sv
module dbgsr_top #(
  parameter int ACT_DLY = 4,
  parameter int TAG_DLY = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        special_mode,
  input  logic        byte_wr,
  input  logic        byte_addr,
  input  logic [7:0]  byte_wdata,
  input  logic        word_wr,
  input  logic [15:0] word_wdata,
  input  logic        rd_addr,
  output logic [7:0]  rd_data,
  input  logic        dbg_enter,
  input  logic        tag_go,
  output logic        map_en,
  output logic        serial_en,
  output logic        tag_en,
  output logic        runaway_err
);
  import dbgsr_pkg::*;

  logic       instr_we, stat_we, via_word;
  logic [7:0] instr_d, stat_d;
  logic [7:0] instr_q;
  logic       en_q, act_q, tag_q;
  flags_t     wf, cur;

  // named internal events
  logic enter_evt, act_load, tag_load, tag_load_val, err_set;
  logic act_pend, act_apply, tag_pend, tag_apply;

  dbgsr_wdec u_wdec (
    .byte_wr   (byte_wr),
    .byte_addr (byte_addr),
    .byte_wdata(byte_wdata),
    .word_wr   (word_wr),
    .word_wdata(word_wdata),
    .instr_we  (instr_we),
    .instr_d   (instr_d),
    .stat_we   (stat_we),
    .stat_d    (stat_d),
    .via_word  (via_word)
  );

  assign wf           = unpack_status(stat_d);
  assign enter_evt    = dbg_enter && en_q;
  assign act_load     = stat_we && !enter_evt;
  assign tag_load     = (tag_go || stat_we) && !enter_evt;
  assign tag_load_val = tag_go ? 1'b1 : wf.tag;
  assign err_set      = stat_we && via_word && act_q && !wf.act && !enter_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= special_mode;
      act_q       <= 1'b0;
      tag_q       <= 1'b0;
      instr_q     <= '0;
      runaway_err <= 1'b0;
    end else begin
      if (instr_we) instr_q <= instr_d;
      if (stat_we)  en_q    <= wf.en;
      if (enter_evt)    act_q <= 1'b1;
      else if (stat_we) act_q <= wf.act;
      if (enter_evt)    tag_q <= 1'b0;
      else if (tag_go)  tag_q <= 1'b1;
      else if (stat_we) tag_q <= wf.tag;
      if (err_set) runaway_err <= 1'b1;
    end
  end

  dbgsr_delay #(.DLY(ACT_DLY)) u_act_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (act_load),
    .load_val (wf.act),
    .force_set(enter_evt),
    .force_val(1'b1),
    .eff      (map_en),
    .pending  (act_pend),
    .apply    (act_apply)
  );

  dbgsr_delay #(.DLY(TAG_DLY)) u_tag_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (tag_load),
    .load_val (tag_load_val),
    .force_set(enter_evt),
    .force_val(1'b0),
    .eff      (tag_en),
    .pending  (tag_pend),
    .apply    (tag_apply)
  );

  assign serial_en = !tag_en;

  always_comb begin
    cur.en  = en_q;
    cur.act = act_q;
    cur.tag = tag_q;
    rd_data = rd_addr ? pack_status(cur) : instr_q;
  end
endmodule

// File: rtl/dbgsr_chk.sv
module dbgsr_chk (
  input logic clk,
  input logic rst,
  input logic dbg_enter,
  input logic en_q,
  input logic enter_evt,
  input logic act_pend,
  input logic act_apply,
  input logic tag_load,
  input logic tag_pend,
  input logic tag_apply,
  input logic map_en,
  input logic tag_en,
  input logic runaway_err
);
  assert_enter_maps_R3: assert property (@(posedge clk) disable iff (rst)
    enter_evt |=> (map_en && !tag_en));

  assert_enter_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (dbg_enter && !en_q && !act_pend) |=> $stable(map_en));

  assert_map_source_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(map_en) |-> ($past(enter_evt) || $past(act_apply)));

  assert_tag_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_en) |-> ($past(tag_apply) && $past(tag_pend)));

  assert_tag_restart_R7: assert property (@(posedge clk) disable iff (rst)
    tag_load |=> $stable(tag_en));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    runaway_err |=> runaway_err);
endmodule

bind dbgsr_top dbgsr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dbg_enter  (dbg_enter),
  .en_q       (en_q),
  .enter_evt  (enter_evt),
  .act_pend   (act_pend),
  .act_apply  (act_apply),
  .tag_load   (tag_load),
  .tag_pend   (tag_pend),
  .tag_apply  (tag_apply),
  .map_en     (map_en),
  .tag_en     (tag_en),
  .runaway_err(runaway_err)
);

// File: tb/tb_dbgsr_top.sv
`timescale 1ns/1ps
module tb_dbgsr_top;
  localparam int A = 3;
  localparam int T = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic special_mode = 1'b0;
  logic byte_wr = 1'b0, byte_addr = 1'b1;
  logic [7:0] byte_wdata = '0;
  logic word_wr = 1'b0;
  logic [15:0] word_wdata = '0;
  logic rd_addr = 1'b1;
  logic [7:0] rd_data;
  logic dbg_enter = 1'b0, tag_go = 1'b0;
  logic map_en, serial_en, tag_en, runaway_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dbgsr_top #(.ACT_DLY(A), .TAG_DLY(T)) dut (
    .clk(clk), .rst(rst), .special_mode(special_mode),
    .byte_wr(byte_wr), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .word_wr(word_wr), .word_wdata(word_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_enter(dbg_enter), .tag_go(tag_go),
    .map_en(map_en), .serial_en(serial_en), .tag_en(tag_en),
    .runaway_err(runaway_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
    rd_addr = 1'b1;
  endtask

  task automatic do_reset(input logic sm);
    rst = 1'b1;
    special_mode = sm;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    byte_wr = 1'b1; byte_addr = 1'b1; byte_wdata = v;
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic wr_word(input logic [15:0] w);
    word_wr = 1'b1; word_wdata = w;
    @(negedge clk);
    word_wr = 1'b0;
  endtask

  task automatic pulse_enter();
    dbg_enter = 1'b1;
    @(negedge clk);
    dbg_enter = 1'b0;
  endtask

  task automatic pulse_tag();
    tag_go = 1'b1;
    @(negedge clk);
    tag_go = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic pm, pt, em, et;

    // R1: reset state, both reset modes
    @(negedge clk);
    do_reset(1'b0);
    rd(1'b1, d); chk("R1 status sm0", d, 8'h00);
    rd(1'b0, d); chk("R1 instr", d, 8'h00);
    chk("R1 map_en", map_en, 0); chk("R1 serial_en", serial_en, 1);
    chk("R1 tag_en", tag_en, 0); chk("R1 err", runaway_err, 0);
    do_reset(1'b1);
    rd(1'b1, d); chk("R1 status sm1", d, 8'h80);

    // R4: entry ignored while disabled
    do_reset(1'b0);
    pulse_enter();
    rd(1'b1, d); chk("R4 status", d, 8'h00);
    repeat (2) begin
      @(negedge clk);
      chk("R4 map_en", map_en, 0);
    end

    // R2/R5/R6: sweep all flag combinations, every cycle of the windows
    do_reset(1'b1);
    pm = 1'b0; pt = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] f;
      f = 3'(v);
      wr_stat({f, 5'h1f});
      rd(1'b1, d); chk("R2 status read", d, {f, 5'h00});
      for (int i = 1; i <= T; i++) begin
        @(negedge clk);
        em = (i >= A) ? f[1] : pm;
        et = (i >= T) ? f[0] : pt;
        chk("R5 map_en timing", map_en, em);
        chk("R6 tag_en timing", tag_en, et);
        chk("R6 serial_en", serial_en, !et);
      end
      pm = f[1]; pt = f[0];
    end
    chk("R9 no err from byte writes", runaway_err, 0);

    // R3: entry maps at once, clears tagging
    do_reset(1'b0);
    wr_stat(8'hA0);
    repeat (T) @(negedge clk);
    chk("R3 tag armed before entry", tag_en, 1);
    pulse_enter();
    chk("R3 map_en", map_en, 1); chk("R3 tag_en", tag_en, 0);
    chk("R3 serial_en", serial_en, 1);
    rd(1'b1, d); chk("R3 status", d, 8'hC0);
    // R3: entry cancels a pending clear
    wr_stat(8'h80);
    pulse_enter();
    for (int i = 1; i <= A + 1; i++) begin
      @(negedge clk);
      chk("R3 pending cancelled", map_en, 1);
    end

    // R7: restart with the same value delays the rise
    do_reset(1'b1);
    wr_stat(8'hC0);
    wr_stat(8'hC0);
    for (int j = 1; j <= A + 1; j++) begin
      @(negedge clk);
      chk("R7 restart same", map_en, (j >= A) ? 1'b1 : 1'b0);
    end
    // R7: restart with a new value discards the old one
    do_reset(1'b1);
    wr_stat(8'hC0);
    wr_stat(8'h80);
    for (int j = 1; j <= A + 1; j++) begin
      @(negedge clk);
      chk("R7 restart new", map_en, 0);
    end

    // R6: tag_go command
    do_reset(1'b0);
    pulse_tag();
    rd(1'b1, d); chk("R6 tag flag read", d, 8'h20);
    for (int i = 1; i <= T; i++) begin
      @(negedge clk);
      chk("R6 tag_go timing", tag_en, (i >= T) ? 1'b1 : 1'b0);
      chk("R6 serial_en", serial_en, (i >= T) ? 1'b0 : 1'b1);
    end
    pulse_enter();
    chk("R4 tag kept when disabled", tag_en, 1);

    // R8: word write splits into both bytes
    do_reset(1'b0);
    wr_word(16'h5A80);
    rd(1'b0, d); chk("R8 instr byte", d, 8'h5A);
    rd(1'b1, d); chk("R8 status byte", d, 8'h80);

    // R9: runaway error
    do_reset(1'b1);
    pulse_enter();
    wr_stat(8'h80);
    chk("R9 byte clear no err", runaway_err, 0);
    repeat (A) @(negedge clk);
    chk("R5 map_en cleared", map_en, 0);
    pulse_enter();
    wr_word(16'hC400);
    chk("R9 err set", runaway_err, 1);
    rd(1'b0, d); chk("R8 instr C4", d, 8'hC4);
    rd(1'b1, d); chk("R8 status 00", d, 8'h00);
    wr_word(16'h0000);
    repeat (A + 2) @(negedge clk);
    chk("R9 err sticky", runaway_err, 1);
    chk("R5 map_en after word clear", map_en, 0);
    do_reset(1'b0);
    chk("R1 err cleared by reset", runaway_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule